// File: doc/BRIEF.md
# Clear-on-Read Interrupt Request Hub

This block gathers four interrupt request sources of a small 4-bit microcontroller into one level-sensitive interrupt line for the CPU. The sources are a prescaler tick (one of three tick rates, picked by a configuration field), a timer/event counter pulse, and one summary event each for port A and port C. Each source pulse sets a pending flag. A flag leads to an interrupt only when its mask bit and the global enable bit are also set.

Software sees the block through a small register bus with an address, a write strobe and a read strobe. Reading the main request register returns all four flags and clears the two internal flags (prescaler and timer). The two port flags stay pending until software reads that port's own request register. A pulse that lands in the same cycle as a clearing read keeps its flag set, so no request is lost. A halt input sets the global enable by itself unless a hold input suppresses it. Entering sleep, which is a guarded write to the main request address, forces the enable to 0. No data stream passes through this block, so every pin is a plain control or status signal with no valid/ready handshake.

Top module: `irq_hub`

## Requirements
- R1: A read of address 0 returns bit 3 = prescaler flag, bit 2 = timer flag, bit 1 = port C flag and bit 0 = port A flag. Read data is registered: it appears the cycle after the read strobe and holds until the next read.
- R2: `irq_o` is a register. It is 1 exactly when, in the previous cycle, the global enable was 1 and at least one flag had its mask bit set.
- R3: After reset, all flags, all mask bits, the global enable, the sleep-guard bit, the rate field and `sleep_o` are 0.
- R4: A read of address 0 clears the prescaler and timer flags and leaves the port A and port C flags unchanged.
- R5: A read of address 3 returns the port A flag in bit 0 (other bits 0) and clears only that flag. A read of address 4 does the same for the port C flag.
- R6: When a source pulse arrives in the same cycle as a read that would clear its flag, the flag stays set.
- R7: A `halt_i` pulse sets the global enable to 1 unless `halt_hold_i` is high in that cycle.
- R8: A write to address 0 with bit 2 = 1 enters sleep (`sleep_o` = 1) and clears the global enable, but only when the sleep-guard bit is 1. Otherwise the write has no effect. `wake_i` leaves sleep, except in a cycle where sleep is being entered.
- R9: Control field rate (bits 3:2) picks the prescaler source: 00 = `tick_32_i`, 01 = `tick_8_i`, 10 = `tick_1_i`, 11 = no prescaler requests.
- R10: Address 1 is the read/write mask register, with the same bit layout as R1. Address 2 is the read/write control register: bit 0 = global enable, bit 1 = sleep guard, bits 3:2 = rate. Reads of addresses 5 to 7 return 0.
- R11: When sleep entry and halt happen in the same cycle, the enable ends at 0. When halt and a control write happen in the same cycle, the enable ends at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_32_i | input | 1 | Fast prescaler tick pulse |
| tick_8_i | input | 1 | Middle prescaler tick pulse |
| tick_1_i | input | 1 | Slow prescaler tick pulse |
| tmr_evt_i | input | 1 | Timer/event counter request pulse |
| pa_evt_i | input | 1 | Port A summary request pulse |
| pc_evt_i | input | 1 | Port C summary request pulse |
| halt_i | input | 1 | Halt instruction executed |
| halt_hold_i | input | 1 | Suppresses the enable set by halt |
| wake_i | input | 1 | Leave sleep mode |
| bus_addr_i | input | 3 | Register address |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | 4 | Write data |
| bus_rd_i | input | 1 | Read strobe |
| bus_rdata_o | output | 4 | Registered read data |
| irq_o | output | 1 | Interrupt request to the CPU |
| sleep_o | output | 1 | Sleep mode state |

## Verification
The assertions assume that a read and a write never happen in the same cycle and that every input pulse is synchronous to `clk`. They make no assumption about how often sources fire or about the order of the bus accesses. The stimulus issues at most one bus access per cycle. It fires sources, halt, hold and wake at random alongside reads and writes, so pulse-with-clear and halt-with-write collisions occur. Directed sequences target the sleep guard, the halt priority and each rate setting.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
  localparam int NSRC = 4;
  localparam int DW   = 4;
  localparam int AW   = 3;

  localparam logic [AW-1:0] A_REQ  = 3'd0;
  localparam logic [AW-1:0] A_MASK = 3'd1;
  localparam logic [AW-1:0] A_CTRL = 3'd2;
  localparam logic [AW-1:0] A_PRTA = 3'd3;
  localparam logic [AW-1:0] A_PRTC = 3'd4;

  localparam int S_PA = 0;
  localparam int S_PC = 1;
  localparam int S_TM = 2;
  localparam int S_PR = 3;

  localparam int SLEEP_BIT = 2;

  typedef enum logic [1:0] {
    RATE_FAST = 2'b00,
    RATE_MID  = 2'b01,
    RATE_SLOW = 2'b10,
    RATE_OFF  = 2'b11
  } rate_e;

  typedef struct packed {
    rate_e rate;
    logic  slm;
    logic  en;
  } ctrl_t;
endpackage

// File: rtl/irq_rate_sel.sv
module irq_rate_sel
  import irq_hub_pkg::*;
(
  input  logic  t_fast_i,
  input  logic  t_mid_i,
  input  logic  t_slow_i,
  input  rate_e rate_i,
  output logic  tick_o
);
  always_comb begin
    case (rate_i)
      RATE_FAST: tick_o = t_fast_i;
      RATE_MID:  tick_o = t_mid_i;
      RATE_SLOW: tick_o = t_slow_i;
      default:   tick_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic q;
    always_ff @(posedge clk) begin
      if (!rst_n)        q <= 1'b0;
      else if (set_i[i]) q <= 1'b1;
      else if (clr_i[i]) q <= 1'b0;
    end
    assign flag_o[i] = q;

    // R6: a set pulse is never lost to a concurrent clear
    p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[i] |=> flag_o[i]);
    // R4: clear without set empties the flag
    p_clear_takes_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[i] && !set_i[i]) |=> !flag_o[i]);
  end
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_hub_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          halt_i,
  input  logic          hold_i,
  input  logic          wake_i,
  output logic [DW-1:0] mask_o,
  output ctrl_t         ctrl_o,
  output logic          sleep_o
);
  logic [DW-1:0] mask_q;
  ctrl_t         ctrl_q, ctrl_d;
  logic          sleep_q, sleep_d, sleep_entry;

  always_comb begin
    sleep_entry = wr_i && (addr_i == A_REQ) && wdata_i[SLEEP_BIT] && ctrl_q.slm;
    ctrl_d = ctrl_q;
    if (wr_i && addr_i == A_CTRL) ctrl_d = ctrl_t'(wdata_i);
    if (sleep_entry)              ctrl_d.en = 1'b0;
    else if (halt_i && !hold_i)   ctrl_d.en = 1'b1;
    if (sleep_entry)              sleep_d = 1'b1;
    else if (wake_i)              sleep_d = 1'b0;
    else                          sleep_d = sleep_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q  <= '0;
      ctrl_q  <= '0;
      sleep_q <= 1'b0;
    end else begin
      if (wr_i && addr_i == A_MASK) mask_q <= wdata_i;
      ctrl_q  <= ctrl_d;
      sleep_q <= sleep_d;
    end
  end

  assign mask_o  = mask_q;
  assign ctrl_o  = ctrl_q;
  assign sleep_o = sleep_q;

  p_halt_sets_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_i && !hold_i && !(wr_i && addr_i == A_REQ && wdata_i[SLEEP_BIT] && ctrl_o.slm))
    |=> ctrl_o.en);
  p_sleep_clears_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && addr_i == A_REQ && wdata_i[SLEEP_BIT] && ctrl_o.slm) |=> (sleep_o && !ctrl_o.en));
  p_guard_blocks_sleep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep_o && !ctrl_o.slm) |=> !sleep_o);
  p_mask_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_i && addr_i == A_MASK) |=> $stable(mask_o));
endmodule

// File: rtl/irq_hub.sv
module irq_hub
  import irq_hub_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_32_i,
  input  logic          tick_8_i,
  input  logic          tick_1_i,
  input  logic          tmr_evt_i,
  input  logic          pa_evt_i,
  input  logic          pc_evt_i,
  input  logic          halt_i,
  input  logic          halt_hold_i,
  input  logic          wake_i,
  input  logic [2:0]    bus_addr_i,
  input  logic          bus_wr_i,
  input  logic [3:0]    bus_wdata_i,
  input  logic          bus_rd_i,
  output logic [3:0]    bus_rdata_o,
  output logic          irq_o
  , output logic        sleep_o
);
  logic [NSRC-1:0] flags, set_v, clr_v, mask;
  ctrl_t           ctrl;
  logic            presc_tick;
  logic [DW-1:0]   rd_mux, rdata_q;
  logic            irq_q;

  irq_rate_sel u_rate (
    .t_fast_i (tick_32_i),
    .t_mid_i  (tick_8_i),
    .t_slow_i (tick_1_i),
    .rate_i   (ctrl.rate),
    .tick_o   (presc_tick)
  );

  irq_cfg_regs u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (bus_wr_i),
    .addr_i  (bus_addr_i),
    .wdata_i (bus_wdata_i),
    .halt_i  (halt_i),
    .hold_i  (halt_hold_i),
    .wake_i  (wake_i),
    .mask_o  (mask),
    .ctrl_o  (ctrl),
    .sleep_o (sleep_o)
  );

  always_comb begin
    set_v       = '0;
    set_v[S_PA] = pa_evt_i;
    set_v[S_PC] = pc_evt_i;
    set_v[S_TM] = tmr_evt_i;
    set_v[S_PR] = presc_tick;
    clr_v       = '0;
    if (bus_rd_i) begin
      case (bus_addr_i)
        A_REQ:  begin clr_v[S_PR] = 1'b1; clr_v[S_TM] = 1'b1; end
        A_PRTA: clr_v[S_PA] = 1'b1;
        A_PRTC: clr_v[S_PC] = 1'b1;
        default: clr_v = '0;
      endcase
    end
  end

  irq_pend_bank #(.N(NSRC)) u_pend (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (set_v),
    .clr_i  (clr_v),
    .flag_o (flags)
  );

  always_comb begin
    case (bus_addr_i)
      A_REQ:   rd_mux = flags;
      A_MASK:  rd_mux = mask;
      A_CTRL:  rd_mux = ctrl;
      A_PRTA:  rd_mux = {{(DW-1){1'b0}}, flags[S_PA]};
      A_PRTC:  rd_mux = {{(DW-1){1'b0}}, flags[S_PC]};
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (bus_rd_i) rdata_q <= rd_mux;
      irq_q <= ctrl.en & (|(flags & mask));
    end
  end

  assign bus_rdata_o = rdata_q;
  assign irq_o       = irq_q;

  p_irq_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(ctrl.en));
  p_port_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_i && bus_addr_i == A_REQ && flags[S_PA]) |=> flags[S_PA]);
  p_snapshot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_i && bus_addr_i == A_REQ) |=> (bus_rdata_o == $past(flags)));
  p_off_rate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.rate == RATE_OFF && !bus_rd_i && !flags[S_PR]) |=> !flags[S_PR]);
endmodule

// File: tb/sim_irq_hub.sv
module sim_irq_hub;
  logic clk = 1'b0, rst_n = 1'b0;
  logic t32, t8, t1, tmr, pa, pc, halt, hold, wake, wr, rd;
  logic [2:0] addr;
  logic [3:0] wdata, rdata;
  logic irq, slp;

  int n_chk = 0, n_bad = 0;
  logic [3:0] m_flags, m_mask, m_rd;
  logic m_en, m_slm, m_sleep, m_irq;
  logic [1:0] m_rate;

  always #5 clk = ~clk;

  irq_hub u0 (
    .clk(clk), .rst_n(rst_n), .tick_32_i(t32), .tick_8_i(t8), .tick_1_i(t1),
    .tmr_evt_i(tmr), .pa_evt_i(pa), .pc_evt_i(pc), .halt_i(halt),
    .halt_hold_i(hold), .wake_i(wake), .bus_addr_i(addr), .bus_wr_i(wr),
    .bus_wdata_i(wdata), .bus_rd_i(rd), .bus_rdata_o(rdata), .irq_o(irq),
    .sleep_o(slp)
  );

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] read_val(input logic [2:0] a);
    case (a)
      3'd0: return m_flags;
      3'd1: return m_mask;
      3'd2: return {m_rate, m_slm, m_en};
      3'd3: return {3'b0, m_flags[0]};
      3'd4: return {3'b0, m_flags[1]};
      default: return 4'h0;
    endcase
  endfunction

  function automatic string rd_tag(input logic [2:0] a);
    case (a)
      3'd0: return "R1";
      3'd3, 3'd4: return "R5";
      default: return "R10";
    endcase
  endfunction

  // ev = {t32,t8,t1,tmr,pc,pa}
  task automatic step(input logic r, input logic w, input logic [2:0] a, input logic [3:0] wd,
                      input logic [5:0] ev, input logic hl, input logic hd, input logic wk);
    logic pr, entry;
    logic [3:0] setv, clrv;
    rd = r; wr = w; addr = a; wdata = wd;
    {t32, t8, t1, tmr, pc, pa} = ev; halt = hl; hold = hd; wake = wk;
    m_irq = m_en && ((m_flags & m_mask) != 4'h0);
    if (r) m_rd = read_val(a);
    case (m_rate)
      2'd0: pr = ev[5];
      2'd1: pr = ev[4];
      2'd2: pr = ev[3];
      default: pr = 1'b0;
    endcase
    setv = {pr, ev[2], ev[1], ev[0]};
    clrv = 4'h0;
    if (r && a == 3'd0) clrv = 4'b1100;
    if (r && a == 3'd3) clrv = 4'b0001;
    if (r && a == 3'd4) clrv = 4'b0010;
    m_flags = (m_flags & ~clrv) | setv;
    entry = w && a == 3'd0 && wd[2] && m_slm;
    if (w && a == 3'd1) m_mask = wd;
    if (w && a == 3'd2) begin m_en = wd[0]; m_slm = wd[1]; m_rate = wd[3:2]; end
    if (entry) m_en = 1'b0;
    else if (hl && !hd) m_en = 1'b1;
    if (entry) m_sleep = 1'b1;
    else if (wk) m_sleep = 1'b0;
    @(posedge clk);
    @(negedge clk);
    rd = 0; wr = 0; addr = 0; wdata = 0;
    {t32, t8, t1, tmr, pc, pa} = 6'b0; halt = 0; hold = 0; wake = 0;
    chk("R2 irq", {3'b0, irq}, {3'b0, m_irq});
    chk("R8 sleep", {3'b0, slp}, {3'b0, m_sleep});
    if (r) chk(rd_tag(a), rdata, m_rd);
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [3:0] exp, input string tag);
    step(1, 0, a, 0, 6'b0, 0, 0, 0);
    chk(tag, rdata, exp);
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [3:0] d);
    step(0, 1, a, d, 6'b0, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rd = 0; wr = 0; addr = 0; wdata = 0; {t32, t8, t1, tmr, pc, pa} = 6'b0;
    halt = 0; hold = 0; wake = 0;
    m_flags = 0; m_mask = 0; m_en = 0; m_slm = 0; m_sleep = 0; m_rate = 0; m_rd = 0; m_irq = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R3 reset state
    chk("R3 irq", {3'b0, irq}, 4'h0);
    chk("R3 sleep", {3'b0, slp}, 4'h0);
    rd_chk(3'd1, 4'h0, "R3 mask");
    rd_chk(3'd2, 4'h0, "R3 ctrl");
    rd_chk(3'd0, 4'h0, "R3 flags");
    // R9 rate select
    wr_reg(3'd2, 4'b0101);
    step(0, 0, 0, 0, 6'b100000, 0, 0, 0);
    rd_chk(3'd0, 4'h0, "R9 fast ignored at mid rate");
    step(0, 0, 0, 0, 6'b010000, 0, 0, 0);
    rd_chk(3'd0, 4'b1000, "R9 mid tick");
    wr_reg(3'd2, 4'b1100);
    step(0, 0, 0, 0, 6'b111000, 0, 0, 0);
    rd_chk(3'd0, 4'h0, "R9 off rate");
    wr_reg(3'd2, 4'b1000);
    step(0, 0, 0, 0, 6'b001000, 0, 0, 0);
    rd_chk(3'd0, 4'b1000, "R9 slow tick");
    // R4 main read clears only internal flags
    step(0, 0, 0, 0, 6'b000111, 0, 0, 0);
    rd_chk(3'd0, 4'b0111, "R4 first read");
    rd_chk(3'd0, 4'b0011, "R4 ports kept");
    // R5 port reads
    rd_chk(3'd3, 4'b0001, "R5 port A");
    rd_chk(3'd0, 4'b0010, "R5 only A cleared");
    rd_chk(3'd4, 4'b0001, "R5 port C");
    rd_chk(3'd0, 4'b0000, "R5 all clear");
    // R6 pulse during clearing read
    step(1, 0, 3'd0, 0, 6'b000100, 0, 0, 0);
    chk("R6 snapshot", rdata, 4'h0);
    rd_chk(3'd0, 4'b0100, "R6 kept");
    step(1, 0, 3'd3, 0, 6'b000001, 0, 0, 0);
    rd_chk(3'd3, 4'b0001, "R6 port kept");
    // R2 gating
    step(0, 0, 0, 0, 6'b000100, 0, 0, 0);
    wr_reg(3'd1, 4'b0100);
    wr_reg(3'd2, 4'b0001);
    step(0, 0, 0, 0, 6'b0, 0, 0, 0);
    chk("R2 irq high", {3'b0, irq}, 4'h1);
    wr_reg(3'd1, 4'b0011);
    step(0, 0, 0, 0, 6'b0, 0, 0, 0);
    chk("R2 masked", {3'b0, irq}, 4'h0);
    // R7 halt
    wr_reg(3'd2, 4'b0000);
    step(0, 0, 0, 0, 6'b0, 1, 1, 0);
    rd_chk(3'd2, 4'b0000, "R7 held");
    step(0, 0, 0, 0, 6'b0, 1, 0, 0);
    rd_chk(3'd2, 4'b0001, "R7 halt sets");
    // R8 sleep guard
    wr_reg(3'd0, 4'b0100);
    chk("R8 guarded", {3'b0, slp}, 4'h0);
    wr_reg(3'd2, 4'b0011);
    wr_reg(3'd0, 4'b0100);
    chk("R8 sleeping", {3'b0, slp}, 4'h1);
    rd_chk(3'd2, 4'b0010, "R8 en cleared");
    step(0, 0, 0, 0, 6'b0, 0, 0, 1);
    chk("R8 wake", {3'b0, slp}, 4'h0);
    // R11 priorities
    step(0, 1, 3'd0, 4'b0100, 6'b0, 1, 0, 0);
    rd_chk(3'd2, 4'b0010, "R11 sleep beats halt");
    step(0, 1, 3'd2, 4'b0000, 6'b0, 1, 0, 1);
    rd_chk(3'd2, 4'b0001, "R11 halt beats write");
    rd_chk(3'd6, 4'h0, "R10 unused address");
    // random phase
    void'($urandom(32'h1A2B3C4D));
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] op;
      logic [2:0] a;
      op = 4'($urandom % 10);
      a = 3'($urandom % 6);
      step(op < 4, op >= 4 && op < 7, a, 4'($urandom), 6'($urandom & $urandom),
           ($urandom % 8) == 0, ($urandom % 3) == 0, ($urandom % 6) == 0);
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule